// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit lets an 8-bit processor reach individual bytes of a program memory that is built from 16-bit words. Software loads a 22-bit byte pointer through three byte-wide registers and can read them back. An 8-bit data latch holds the byte moving between the program memory and the data side. Each read or write command moves exactly one byte between the latch and the memory.

A command also carries one of four pointer operations. The operation is applied to the low 21 bits, which span a 2-Mbyte program space. The top pointer bit selects configuration space and is never altered by the arithmetic.

Reads go through a synchronous 16-bit word port with one cycle of latency. Writes present the latch byte, the word address and a byte select on a holding-register write port. Flash programming itself takes place elsewhere.

Top module: `prog_table_access`

## Requirements
- R1: After reset the pointer and the latch read as zero, `busy` is low, and neither `mem_rd_en` nor `hold_wr_en` is asserted.
- R2: `reg_sel` picks a register: 0 is pointer bits 7:0, 1 is pointer bits 15:8, 2 is pointer bits 21:16 in bits 5:0, and 3 is the latch. `reg_rdata` shows the selected register at once. Bits 7:6 of selection 2 always read zero, and writes to them are ignored.
- R3: A read command (`cmd_write`=0) accepted at an edge drives `mem_rd_en` high in the next cycle, with `mem_addr` equal to access pointer bits 21:1. Memory returns the word one cycle later. The latch is loaded at the end of that cycle, and `busy` is high for exactly those two cycles.
- R4: Access pointer bit 0 picks the byte. A value of 1 takes word bits 15:8, and 0 takes bits 7:0.
- R5: A write command (`cmd_write`=1) drives `hold_wr_en` high for one cycle, starting one cycle after acceptance. In that cycle `hold_addr` is access pointer bits 21:1, `hold_hi_sel` is access pointer bit 0 and `hold_wdata` is the latch. `busy` is high only in that cycle, and the latch is left unchanged.
- R6: `cmd_mode` selects the pointer operation: 0 keeps the pointer, 1 increments it after the access, 2 decrements it after the access, 3 increments it before the access. In mode 3 the access uses the incremented pointer.
- R7: Increment and decrement wrap within bits 20:0 (0x1FFFFF+1 gives 0x000000, 0x000000-1 gives 0x1FFFFF). Bit 21 is kept in both cases.
- R8: Pointer bit 21 reaches memory as the top word-address bit, so configuration space is addressed by all 22 bits.
- R9: The updated pointer is written at the same edge that ends the access, so the registers hold the new value when `busy` falls.
- R10: A command that arrives while `busy` is high is ignored.
- R11: A register write is ignored if it comes while `busy` is high or at the same edge a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_mode | input | 2 | Pointer operation |
| busy | output | 1 | Access in progress |
| mem_rd_en | output | 1 | Word read request |
| mem_addr | output | 21 | Word address for the read |
| mem_rdata | input | 16 | Read word, one cycle after the request |
| hold_wr_en | output | 1 | Holding-register write strobe |
| hold_addr | output | 21 | Word address for the write |
| hold_hi_sel | output | 1 | 1 selects the high byte of the word |
| hold_wdata | output | 8 | Byte to write |

## Verification
The bench drives the pointer across both wrap points, with the configuration bit set and with it clear. A design that carried out of bit 20 would flip configuration space, and one that wrapped over 22 bits would read back 0x000000 or 0x3FFFFF instead. Pre-increment is checked on the memory address itself, because a design that used the old pointer for the access would still end with the correct final pointer. Byte selection is checked on both odd and even pointers to catch swapped halves. Commands and register writes are issued while the unit is busy and at the acceptance edge, to catch a design that restarts an access or lets software corrupt the pointer in flight.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

    typedef enum logic [1:0] {
        PM_KEEP     = 2'd0,
        PM_POST_INC = 2'd1,
        PM_POST_DEC = 2'd2,
        PM_PRE_INC  = 2'd3
    } ptr_mode_e;

    typedef enum logic [1:0] {
        SEL_LOW   = 2'd0,
        SEL_HIGH  = 2'd1,
        SEL_UPPER = 2'd2,
        SEL_LATCH = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_REQ = 2'd1,
        ST_RD_CAP = 2'd2,
        ST_WR_PUT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/ptab_ptr_math.sv
module ptab_ptr_math
    import ptab_pkg::*;
#(
    parameter int PTR_W   = 22,
    parameter int SPACE_W = 21
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [1:0]       mode_i,
    output logic [PTR_W-1:0] acc_o,
    output logic [PTR_W-1:0] next_o
);
    localparam int CFG_W = PTR_W - SPACE_W;
    localparam logic [SPACE_W-1:0] ONE = {{(SPACE_W-1){1'b0}}, 1'b1};

    logic [CFG_W-1:0]   cfg_bits;
    logic [SPACE_W-1:0] low_bits;
    logic [PTR_W-1:0]   inc_ptr;
    logic [PTR_W-1:0]   dec_ptr;

    always_comb begin
        cfg_bits = ptr_i[PTR_W-1:SPACE_W];
        low_bits = ptr_i[SPACE_W-1:0];
        inc_ptr  = {cfg_bits, low_bits + ONE};
        dec_ptr  = {cfg_bits, low_bits - ONE};
        case (ptr_mode_e'(mode_i))
            PM_KEEP: begin
                acc_o  = ptr_i;
                next_o = ptr_i;
            end
            PM_POST_INC: begin
                acc_o  = ptr_i;
                next_o = inc_ptr;
            end
            PM_POST_DEC: begin
                acc_o  = ptr_i;
                next_o = dec_ptr;
            end
            default: begin
                acc_o  = inc_ptr;
                next_o = inc_ptr;
            end
        endcase
    end

    // R7: the configuration bits are never altered by the arithmetic
    always_comb begin
        a_r7_cfg_untouched: assert (next_o[PTR_W-1:SPACE_W] == ptr_i[PTR_W-1:SPACE_W]);
    end

endmodule

// File: rtl/ptab_regs.sv
module ptab_regs
    import ptab_pkg::*;
#(
    parameter int PTR_W  = 22,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we_i,
    input  logic [1:0]        sw_sel_i,
    input  logic [DATA_W-1:0] sw_wdata_i,
    input  logic              lock_i,
    input  logic              upd_en_i,
    input  logic [PTR_W-1:0]  upd_ptr_i,
    input  logic              lat_ld_i,
    input  logic [DATA_W-1:0] lat_val_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [DATA_W-1:0] lat_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int SLOTS  = (PTR_W + DATA_W - 1) / DATA_W;
    localparam int WIDE_W = SLOTS * DATA_W;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] lat;
    } regs_t;

    regs_t r_d, r_q;

    logic [WIDE_W-1:0] wide_ptr;
    logic [DATA_W-1:0] slot_rd [SLOTS];
    logic [PTR_W-1:0]  ptr_wr;

    assign wide_ptr = WIDE_W'(r_q.ptr);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_rd[g] = wide_ptr[g*DATA_W +: DATA_W];
    end

    always_comb begin
        ptr_wr = r_q.ptr;
        for (int i = 0; i < PTR_W; i++) begin
            if ((i / DATA_W) == int'(sw_sel_i)) begin
                ptr_wr[i] = sw_wdata_i[i % DATA_W];
            end
        end
    end

    always_comb begin
        r_d = r_q;
        if (sw_we_i && !lock_i) begin
            if (reg_sel_e'(sw_sel_i) == SEL_LATCH) begin
                r_d.lat = sw_wdata_i;
            end else begin
                r_d.ptr = ptr_wr;
            end
        end
        if (upd_en_i) begin
            r_d.ptr = upd_ptr_i;
        end
        if (lat_ld_i) begin
            r_d.lat = lat_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(sw_sel_i))
            SEL_LOW:   rdata_o = slot_rd[0];
            SEL_HIGH:  rdata_o = slot_rd[1];
            SEL_UPPER: rdata_o = slot_rd[2];
            default:   rdata_o = r_q.lat;
        endcase
    end

    assign ptr_o = r_q.ptr;
    assign lat_o = r_q.lat;

    // R11: while locked, only the access itself may change the state
    a_r11_locked_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !upd_en_i && !lat_ld_i) |=> ($stable(r_q.ptr) && $stable(r_q.lat)));

    // R7: the configuration bit survives every pointer update
    a_r7_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |=> (r_q.ptr[PTR_W-1] == $past(r_q.ptr[PTR_W-1])));

    // R2: unused upper register bits read as zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sel_i == 2'd2) |-> ((rdata_o >> (PTR_W - 2*DATA_W)) == '0));

endmodule

// File: rtl/ptab_ctrl.sv
module ptab_ctrl
    import ptab_pkg::*;
#(
    parameter int PTR_W  = 22,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid_i,
    input  logic                cmd_write_i,
    input  logic [PTR_W-1:0]    acc_i,
    input  logic [PTR_W-1:0]    next_i,
    input  logic [DATA_W-1:0]   lat_i,
    input  logic [2*DATA_W-1:0] mem_rdata_i,
    output logic                busy_o,
    output logic                lock_o,
    output logic                mem_rd_en_o,
    output logic [PTR_W-2:0]    mem_addr_o,
    output logic                hold_wr_en_o,
    output logic [PTR_W-2:0]    hold_addr_o,
    output logic                hold_hi_o,
    output logic [DATA_W-1:0]   hold_wdata_o,
    output logic                upd_en_o,
    output logic [PTR_W-1:0]    upd_ptr_o,
    output logic                lat_ld_o,
    output logic [DATA_W-1:0]   lat_val_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [PTR_W-1:0] acc;
        logic [PTR_W-1:0] nxt;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    assign accept = (s_q.st == ST_IDLE) && cmd_valid_i;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    s_d.acc = acc_i;
                    s_d.nxt = next_i;
                    s_d.st  = cmd_write_i ? ST_WR_PUT : ST_RD_REQ;
                end
            end
            ST_RD_REQ: s_d.st = ST_RD_CAP;
            default:   s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, acc: '0, nxt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy_o       = (s_q.st != ST_IDLE);
        lock_o       = busy_o || accept;
        mem_rd_en_o  = (s_q.st == ST_RD_REQ);
        mem_addr_o   = s_q.acc[PTR_W-1:1];
        hold_wr_en_o = (s_q.st == ST_WR_PUT);
        hold_addr_o  = s_q.acc[PTR_W-1:1];
        hold_hi_o    = s_q.acc[0];
        hold_wdata_o = lat_i;
        lat_ld_o     = (s_q.st == ST_RD_CAP);
        upd_en_o     = lat_ld_o || hold_wr_en_o;
        upd_ptr_o    = s_q.nxt;
        lat_val_o    = s_q.acc[0] ? mem_rdata_i[2*DATA_W-1:DATA_W]
                                  : mem_rdata_i[DATA_W-1:0];
    end

    // R3: the latch is loaded exactly one cycle after the read request
    a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> (lat_ld_o && !mem_rd_en_o));

    // R5: a write occupies a single busy cycle
    a_r5_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr_en_o |=> !hold_wr_en_o);

    // R10: an access always ends idle, whatever arrives meanwhile
    a_r10_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_o |=> !mem_rd_en_o && !hold_wr_en_o && !lat_ld_o);

    // R3: read and write strobes never overlap
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en_o && hold_wr_en_o));

endmodule

// File: rtl/prog_table_access.sv
module prog_table_access #(
    parameter int PTR_W   = 22,
    parameter int SPACE_W = 21,
    parameter int DATA_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                cmd_valid,
    input  logic                cmd_write,
    input  logic [1:0]          cmd_mode,
    output logic                busy,
    output logic                mem_rd_en,
    output logic [PTR_W-2:0]    mem_addr,
    input  logic [2*DATA_W-1:0] mem_rdata,
    output logic                hold_wr_en,
    output logic [PTR_W-2:0]    hold_addr,
    output logic                hold_hi_sel,
    output logic [DATA_W-1:0]   hold_wdata
);
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] lat;
    logic [PTR_W-1:0]  acc_ptr;
    logic [PTR_W-1:0]  next_ptr;
    logic              lock;
    logic              upd_en;
    logic [PTR_W-1:0]  upd_ptr;
    logic              lat_ld;
    logic [DATA_W-1:0] lat_val;

    ptab_ptr_math #(.PTR_W(PTR_W), .SPACE_W(SPACE_W)) u_math (
        .ptr_i  (ptr),
        .mode_i (cmd_mode),
        .acc_o  (acc_ptr),
        .next_o (next_ptr)
    );

    ptab_regs #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we_i    (reg_we),
        .sw_sel_i   (reg_sel),
        .sw_wdata_i (reg_wdata),
        .lock_i     (lock),
        .upd_en_i   (upd_en),
        .upd_ptr_i  (upd_ptr),
        .lat_ld_i   (lat_ld),
        .lat_val_i  (lat_val),
        .ptr_o      (ptr),
        .lat_o      (lat),
        .rdata_o    (reg_rdata)
    );

    ptab_ctrl #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid),
        .cmd_write_i  (cmd_write),
        .acc_i        (acc_ptr),
        .next_i       (next_ptr),
        .lat_i        (lat),
        .mem_rdata_i  (mem_rdata),
        .busy_o       (busy),
        .lock_o       (lock),
        .mem_rd_en_o  (mem_rd_en),
        .mem_addr_o   (mem_addr),
        .hold_wr_en_o (hold_wr_en),
        .hold_addr_o  (hold_addr),
        .hold_hi_o    (hold_hi_sel),
        .hold_wdata_o (hold_wdata),
        .upd_en_o     (upd_en),
        .upd_ptr_o    (upd_ptr),
        .lat_ld_o     (lat_ld),
        .lat_val_o    (lat_val)
    );

    // R1: no memory strobe while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !hold_wr_en));

endmodule

// File: tb/prog_table_access_tb.sv
module prog_table_access_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        cmd_valid;
    logic        cmd_write;
    logic [1:0]  cmd_mode;
    logic        busy;
    logic        mem_rd_en;
    logic [20:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        hold_wr_en;
    logic [20:0] hold_addr;
    logic        hold_hi_sel;
    logic [7:0]  hold_wdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_table_access u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_mode(cmd_mode), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .hold_wr_en(hold_wr_en), .hold_addr(hold_addr), .hold_hi_sel(hold_hi_sel),
        .hold_wdata(hold_wdata)
    );

    function automatic logic [15:0] word_model(logic [20:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + {3'b000, a[20:16]} + 8'h11};
    endfunction

    function automatic logic [7:0] byte_model(logic [21:0] p);
        logic [15:0] w = word_model(p[21:1]);
        return p[0] ? w[15:8] : w[7:0];
    endfunction

    always_ff @(posedge clk) begin
        mem_rdata <= mem_rd_en ? word_model(mem_addr) : 16'h0000;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic set_ptr(input logic [21:0] p);
        reg_write(2'd0, p[7:0]);
        reg_write(2'd1, p[15:8]);
        reg_write(2'd2, {2'b00, p[21:16]});
    endtask

    task automatic get_ptr(output logic [21:0] p);
        logic [7:0] u, h, l;
        reg_read(2'd2, u);
        reg_read(2'd1, h);
        reg_read(2'd0, l);
        p = {u[5:0], h, l};
    endtask

    // read command, checking address, latency, byte, final pointer
    task automatic run_read(input logic [1:0] mode, input logic [21:0] start,
                            input logic [21:0] acc, input logic [21:0] nxt, input string tag);
        logic [21:0] p;
        logic [7:0]  b;
        set_ptr(start);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = mode;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        chk(mem_rd_en && busy, {tag, " R3 request"}, {30'd0, mem_rd_en, busy}, 32'd3);
        chk(mem_addr == acc[21:1], {tag, " R3/R6/R8 address"}, 32'(mem_addr), 32'(acc[21:1]));
        @(negedge clk);
        chk(busy && !mem_rd_en, {tag, " R3 second busy cycle"}, {30'd0, mem_rd_en, busy}, 32'd1);
        @(negedge clk);
        chk(!busy, {tag, " R3 busy ends"}, 32'(busy), 32'd0);
        reg_read(2'd3, b);
        chk(b == byte_model(acc), {tag, " R4 latch byte"}, 32'(b), 32'(byte_model(acc)));
        get_ptr(p);
        chk(p == nxt, {tag, " R6/R7/R9 pointer"}, 32'(p), 32'(nxt));
    endtask

    task automatic t_reset;
        logic [21:0] p;
        logic [7:0]  b;
        get_ptr(p);
        reg_read(2'd3, b);
        chk(p == 22'd0 && b == 8'd0, "R1 reset registers", {2'd0, p, b}, 32'd0);
        chk(!busy && !mem_rd_en && !hold_wr_en, "R1 reset outputs",
            {29'd0, busy, mem_rd_en, hold_wr_en}, 32'd0);
    endtask

    task automatic t_regs;
        logic [7:0] b;
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, b);
        chk(b == 8'h3F, "R2 upper bits read zero", 32'(b), 32'h3F);
        reg_write(2'd0, 8'h34);
        reg_write(2'd1, 8'h12);
        reg_write(2'd3, 8'h77);
        reg_read(2'd0, b);
        chk(b == 8'h34, "R2 low byte", 32'(b), 32'h34);
        reg_read(2'd1, b);
        chk(b == 8'h12, "R2 high byte", 32'(b), 32'h12);
        reg_read(2'd3, b);
        chk(b == 8'h77, "R2 latch", 32'(b), 32'h77);
    endtask

    task automatic t_read_modes;
        run_read(2'd0, 22'h001235, 22'h001235, 22'h001235, "keep");
        run_read(2'd1, 22'h001235, 22'h001235, 22'h001236, "post-inc");
        run_read(2'd2, 22'h001236, 22'h001236, 22'h001235, "post-dec");
        run_read(2'd3, 22'h001235, 22'h001236, 22'h001236, "pre-inc");
    endtask

    task automatic t_wrap;
        run_read(2'd1, 22'h1FFFFF, 22'h1FFFFF, 22'h000000, "R7 wrap up cfg0");
        run_read(2'd3, 22'h3FFFFF, 22'h200000, 22'h200000, "R7 wrap up cfg1");
        run_read(2'd2, 22'h200000, 22'h200000, 22'h3FFFFF, "R7 wrap down cfg1");
        run_read(2'd2, 22'h000000, 22'h000000, 22'h1FFFFF, "R7 wrap down cfg0");
        run_read(2'd0, 22'h2ABC01, 22'h2ABC01, 22'h2ABC01, "R8 config read");
    endtask

    task automatic write_cmd(input logic [1:0] mode, input logic [21:0] start,
                             input logic [21:0] acc, input logic [21:0] nxt, input logic [7:0] data);
        logic [21:0] p;
        logic [7:0]  b;
        set_ptr(start);
        reg_write(2'd3, data);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = mode;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        chk(hold_wr_en && busy && !mem_rd_en, "R5 write strobe",
            {29'd0, hold_wr_en, busy, mem_rd_en}, 32'd6);
        chk(hold_addr == acc[21:1] && hold_hi_sel == acc[0], "R5/R6 write address",
            {10'd0, hold_addr, hold_hi_sel}, {10'd0, acc});
        chk(hold_wdata == data, "R5 write data", 32'(hold_wdata), 32'(data));
        @(negedge clk);
        chk(!busy && !hold_wr_en, "R5 write single cycle", {30'd0, busy, hold_wr_en}, 32'd0);
        get_ptr(p);
        chk(p == nxt, "R9 write pointer update", 32'(p), 32'(nxt));
        reg_read(2'd3, b);
        chk(b == data, "R5 latch kept", 32'(b), 32'(data));
    endtask

    task automatic t_write;
        write_cmd(2'd1, 22'h00ABCD, 22'h00ABCD, 22'h00ABCE, 8'hC3);
        write_cmd(2'd3, 22'h00ABCE, 22'h00ABCF, 22'h00ABCF, 8'h5E);
        write_cmd(2'd2, 22'h200000, 22'h200000, 22'h3FFFFF, 8'h81);
    endtask

    task automatic t_busy;
        logic [21:0] p;
        logic [7:0]  b;
        int strobes = 0;
        set_ptr(22'h000100);
        reg_write(2'd3, 8'h00);
        // register write together with the accepted command
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = 2'd1;
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'hEE;
        @(posedge clk); @(negedge clk);
        // keep a write command and register writes active during busy
        cmd_write = 1'b1; reg_sel = 2'd3; reg_wdata = 8'hAA;
        if (hold_wr_en) strobes++;
        @(negedge clk);
        reg_sel = 2'd1;
        if (hold_wr_en) strobes++;
        @(negedge clk);
        cmd_valid = 1'b0; reg_we = 1'b0;
        chk(strobes == 0 && !busy, "R10 command while busy ignored",
            {31'd0, busy} + 32'(strobes), 32'd0);
        get_ptr(p);
        chk(p == 22'h000101, "R11 pointer writes ignored", 32'(p), 32'h000101);
        reg_read(2'd3, b);
        chk(b == byte_model(22'h000100), "R11 latch write ignored", 32'(b),
            32'(byte_model(22'h000100)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = 8'd0;
        cmd_valid = 1'b0; cmd_write = 1'b0; cmd_mode = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_read_modes();
        t_wrap();
        t_write();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule